// File: doc/BRIEF.md
# Two-Step Flash Code Combiner

This block is the digital back end of an 8-bit two-step (half-flash) converter. Two banks of 15 comparators drive it. The coarse bank sees the input directly, and one more comparator in that bank signals an input above the top of the range. The fine bank sees the residue that is left after a coarse estimate has been subtracted. The block reduces each thermometer vector to a 4-bit code and keeps the coarse code in a register. That register also drives the residue DAC. The block then joins both codes into one output word when the fine phase ends.

The sequencer strobes `coarse_strobe` when the coarse comparators have settled, and `fine_strobe` when the fine comparators have settled. The coarse nibble is latched at the first strobe and appears on `dac_code`. At the second strobe the block loads the 8-bit word and the overflow flag, and `done` pulses once. The word reads as natural binary for a unipolar span and as offset binary for a span centred on zero. Setting `signed_fmt` gives the same word in two's complement.

The controller has three states:
- `ST_IDLE`: nothing is pending.
- `ST_HELD`: a coarse nibble is held and the block waits for the fine strobe.
- `ST_PUBLISH`: the cycle in which `done` is high.

It has these transitions:
- IDLE→HELD on a coarse strobe.
- HELD→HELD on a coarse strobe, which re-latches the coarse nibble.
- HELD→PUBLISH on a fine strobe without a coarse strobe.
- PUBLISH→HELD on a coarse strobe.
- PUBLISH→IDLE otherwise.

Top module: `halfflash_combiner`

## Requirements
- R1: After reset, `result`, `dac_code`, `overflow` and `done` are all zero.
- R2: A thermometer vector made of n ones from bit 0 upward, with the rest zero, encodes to the value n. All zeros gives 0 and all fifteen ones gives 15.
- R3: A vector with bubbles (a zero below a one) encodes to one plus the bit index of its highest one.
- R4: On a coarse strobe, the code of `coarse_therm` appears on `dac_code` from the next cycle. It holds until the next coarse strobe.
- R5: A fine strobe while a coarse nibble is held loads `result` with the coarse code in bits 7:4 and the fine code in bits 3:0.
- R6: `coarse_ovr` is sampled at the coarse strobe. When it is set, the next loaded word saturates to 0xFF (in unsigned format) and `overflow` is 1. Otherwise `overflow` is 0.
- R7: `signed_fmt` is sampled at the fine strobe. When it is 1, bit 7 of the loaded word is inverted, so saturation gives 0x7F.
- R8: `done` is 1 for exactly one cycle: the cycle after the edge at which `result` loads.
- R9: `result` and `overflow` change only at an accepted fine strobe. A fine strobe with no coarse nibble held is ignored and raises no `done`.
- R10: A second coarse strobe before the fine strobe replaces the held nibble. The later coarse code is the one used. If both strobes arrive in the same cycle, the coarse strobe wins and the fine strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coarse_therm | input | 15 | Coarse comparator outputs, bit 0 is the lowest threshold |
| coarse_ovr | input | 1 | Coarse over-range comparator |
| coarse_strobe | input | 1 | End of coarse phase, latch coarse nibble |
| fine_therm | input | 15 | Fine (residue) comparator outputs |
| fine_strobe | input | 1 | End of fine phase, load output word |
| signed_fmt | input | 1 | 1 = two's complement output, 0 = straight code |
| dac_code | output | 4 | Held coarse nibble for the residue DAC |
| result | output | 8 | Assembled conversion word |
| overflow | output | 1 | Over-range flag for the loaded word |
| done | output | 1 | One-cycle pulse after each load |

## Verification
The hardest situations to reach are those where strobes arrive out of the normal order. These are a fine strobe with no coarse nibble held, and a second coarse strobe landing while the first nibble still waits. The stimulus reaches them directly. It sends a lone fine strobe right after a completed conversion and confirms that `result` is unchanged and that no `done` appears. It sends two coarse strobes with different vectors before one fine strobe and expects the second nibble on both `dac_code` and `result`. Bubbled vectors, and vectors with only the top comparator set, exercise the encoder beyond clean thermometer codes.

// File: rtl/hf_pkg.sv
package hf_pkg;
    localparam int NIB_W = 4;
    localparam int NCMP  = (1 << NIB_W) - 1;
    localparam int WORD_W = 2 * NIB_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HELD    = 2'd1,
        ST_PUBLISH = 2'd2
    } hf_state_e;
endpackage

// File: rtl/hf_therm_enc.sv
module hf_therm_enc #(
    parameter int NIB_W = 4,
    localparam int NCMP = (1 << NIB_W) - 1
) (
    input  logic [NCMP-1:0]  therm,
    output logic [NIB_W-1:0] code
);
    // top_one[i] marks a one with only zeros above it; bubbles below are ignored
    logic [NCMP-1:0] top_one;

    genvar g;
    generate
        for (g = 0; g < NCMP; g++) begin : g_top
            if (g == NCMP - 1) begin : g_last
                assign top_one[g] = therm[g];
            end else begin : g_mid
                assign top_one[g] = therm[g] & ~(|therm[NCMP-1:g+1]);
            end
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < NCMP; i++) begin
            if (top_one[i]) code = code | NIB_W'(i + 1);
        end
    end

    // R3: at most one position may be marked as the top one
    always_comb begin
        top_one_chk: assert ($onehot0(top_one));
    end
endmodule

// File: rtl/hf_seq_ctrl.sv
module hf_seq_ctrl
    import hf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      coarse_stb,
    input  logic      fine_stb,
    output logic      coarse_load,
    output logic      fine_load,
    output logic      done
);
    hf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (coarse_stb) state_d = ST_HELD;
            ST_HELD:    if (coarse_stb) state_d = ST_HELD;
                        else if (fine_stb) state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = coarse_stb ? ST_HELD : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        coarse_load = coarse_stb;
        fine_load   = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_HELD:    fine_load = fine_stb & ~coarse_stb;
            ST_PUBLISH: done = 1'b1;
            default:    ;
        endcase
    end

    // R8: the publish state never repeats back to back
    publish_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUBLISH) |=> (state_q != ST_PUBLISH));

    // R9: publish is entered only from the held state
    publish_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUBLISH) |-> ($past(state_q) == ST_HELD));
endmodule

// File: rtl/halfflash_combiner.sv
module halfflash_combiner
    import hf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCMP-1:0]     coarse_therm,
    input  logic                coarse_ovr,
    input  logic                coarse_strobe,
    input  logic [NCMP-1:0]     fine_therm,
    input  logic                fine_strobe,
    input  logic                signed_fmt,
    output logic [NIB_W-1:0]    dac_code,
    output logic [WORD_W-1:0]   result,
    output logic                overflow,
    output logic                done
);
    localparam logic [WORD_W-1:0] SAT_WORD = '1;
    localparam logic [WORD_W-1:0] MSB_MASK = WORD_W'(1) << (WORD_W - 1);

    logic [NIB_W-1:0]  coarse_code, fine_code;
    logic [NIB_W-1:0]  coarse_q;
    logic              ovr_q;
    logic [WORD_W-1:0] result_q, word_d;
    logic              overflow_q;
    logic              coarse_load, fine_load;

    hf_therm_enc #(.NIB_W(NIB_W)) u_enc_coarse (.therm(coarse_therm), .code(coarse_code));
    hf_therm_enc #(.NIB_W(NIB_W)) u_enc_fine   (.therm(fine_therm),   .code(fine_code));

    hf_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .coarse_stb  (coarse_strobe),
        .fine_stb    (fine_strobe),
        .coarse_load (coarse_load),
        .fine_load   (fine_load),
        .done        (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_q <= '0;
            ovr_q    <= 1'b0;
        end else if (coarse_load) begin
            coarse_q <= coarse_code;
            ovr_q    <= coarse_ovr;
        end
    end

    always_comb begin
        word_d = ovr_q ? SAT_WORD : {coarse_q, fine_code};
        if (signed_fmt) word_d = word_d ^ MSB_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q   <= '0;
            overflow_q <= 1'b0;
        end else if (fine_load) begin
            result_q   <= word_d;
            overflow_q <= ovr_q;
        end
    end

    assign dac_code = coarse_q;
    assign result   = result_q;
    assign overflow = overflow_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fine_strobe));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fine_strobe |=> ($stable(result) && $stable(overflow)));

    // R4
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !coarse_strobe |=> $stable(dac_code));

    // R6
    ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (result == SAT_WORD || result == (SAT_WORD ^ MSB_MASK)));
endmodule

// File: tb/halfflash_combiner_tb.sv
module halfflash_combiner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] coarse_therm = '0;
    logic        coarse_ovr = 1'b0;
    logic        coarse_strobe = 1'b0;
    logic [14:0] fine_therm = '0;
    logic        fine_strobe = 1'b0;
    logic        signed_fmt = 1'b0;
    logic [3:0]  dac_code;
    logic [7:0]  result;
    logic        overflow;
    logic        done;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic       done_prev = 1'b0;
    logic [8:0] last_word = '0;

    always #5 clk = ~clk;

    halfflash_combiner u_dut (
        .clk(clk), .rst_n(rst_n),
        .coarse_therm(coarse_therm), .coarse_ovr(coarse_ovr), .coarse_strobe(coarse_strobe),
        .fine_therm(fine_therm), .fine_strobe(fine_strobe), .signed_fmt(signed_fmt),
        .dac_code(dac_code), .result(result), .overflow(overflow), .done(done)
    );

    function automatic logic [3:0] enc(input logic [14:0] v);
        logic [3:0] c = '0;
        for (int i = 0; i < 15; i++) if (v[i]) c = 4'(i + 1);
        return c;
    endfunction

    function automatic logic [14:0] therm(input int n);
        return 15'((32'd1 << n) - 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop expected items as done pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && done_prev) check("R8 done width", 32'd2, 32'd1);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {23'd0, overflow, result}, {23'd0, e});
                    last_word = {overflow, result};
                end
            end
            done_prev = done;
        end
    end

    task automatic coarse_phase(input logic [14:0] cth, input logic ovr, input string tag);
        @(negedge clk);
        coarse_therm = cth; coarse_ovr = ovr; coarse_strobe = 1'b1;
        @(negedge clk);
        coarse_strobe = 1'b0;
        check({tag, " R4 dac_code"}, {28'd0, dac_code}, {28'd0, enc(cth)});
    endtask

    task automatic fine_phase(input logic [14:0] cth, input logic ovr,
                              input logic [14:0] fth, input logic sgn, input string tag);
        logic [7:0] w;
        w = ovr ? 8'hFF : {enc(cth), enc(fth)};
        if (sgn) w = w ^ 8'h80;
        exp_q.push_back({ovr, w});
        tag_q.push_back(tag);
        fine_therm = fth; signed_fmt = sgn; fine_strobe = 1'b1;
        @(negedge clk);
        fine_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic conv(input logic [14:0] cth, input logic [14:0] fth,
                        input logic ovr, input logic sgn, input string tag);
        coarse_phase(cth, ovr, tag);
        fine_phase(cth, ovr, fth, sgn, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_vec++; n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 result", {24'd0, result}, 32'd0);
        check("R1 dac_code", {28'd0, dac_code}, 32'd0);
        check("R1 overflow+done", {30'd0, overflow, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2, R5: clean thermometer codes for every count
        for (int n = 0; n < 16; n++)
            conv(therm(n), therm(15 - n), 1'b0, 1'b0, "R2 R5 clean code");

        // R3: bubbles
        conv(15'b000_0000_0100_1111, 15'b000_0101_1111_1011, 1'b0, 1'b0, "R3 bubble");
        conv(15'b100_0000_0000_0000, 15'b000_0000_0000_0010, 1'b0, 1'b0, "R3 lone top");

        // R6: over-range saturation
        conv(therm(15), therm(9), 1'b1, 1'b0, "R6 saturate");
        conv(therm(3), therm(4), 1'b0, 1'b0, "R6 overflow clears");

        // R7: two's complement presentation
        conv(therm(8), therm(0), 1'b0, 1'b1, "R7 signed zero");
        conv(therm(2), therm(5), 1'b0, 1'b1, "R7 signed negative");
        conv(therm(15), therm(15), 1'b1, 1'b1, "R7 signed saturate");

        // R10: second coarse strobe replaces the held nibble
        coarse_phase(therm(4), 1'b1, "R10 first");
        coarse_phase(therm(11), 1'b0, "R10 second");
        fine_phase(therm(11), 1'b0, therm(6), 1'b0, "R10 latest coarse wins");

        // R9: lone fine strobe is ignored
        @(negedge clk);
        fine_therm = therm(1); fine_strobe = 1'b1;
        @(negedge clk);
        fine_strobe = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 ignored fine strobe", {23'd0, overflow, result}, {23'd0, last_word});
        check("R9 no pending", exp_q.size(), 32'd0);

        // R10: simultaneous strobes, coarse wins and no load happens
        @(negedge clk);
        coarse_therm = therm(13); coarse_ovr = 1'b0; coarse_strobe = 1'b1;
        fine_therm = therm(2); fine_strobe = 1'b1;
        @(negedge clk);
        coarse_strobe = 1'b0; fine_strobe = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 simultaneous dac_code", {28'd0, dac_code}, 32'd13);
        check("R10 simultaneous no load", {23'd0, overflow, result}, {23'd0, last_word});
        fine_phase(therm(13), 1'b0, therm(7), 1'b0, "R10 after simultaneous");

        repeat (3) @(negedge clk);
        check("R8 all results seen", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule